// File: doc/BRIEF.md
# Serial Clock Generator with Pass-Through Mode

This block derives a serial-bus clock from the functional clock, for a serial master whose sequencer needs to know when to shift data out and when to capture data in. A divider setting `N` selects a half-period of `N+1` functional cycles. The all-ones code is reserved and passes the functional clock straight through. A polarity input sets the level the serial clock rests at. A phase input chooses whether data is captured on the first or the second edge of each serial-clock period.

Alongside the pin level, the block emits two single-cycle strobes. The launch strobe marks an edge on which new data should be driven. The sample strobe marks an edge on which incoming data should be captured. A run request starts the clock. Stopping only happens on a whole-period boundary, so the pin never stops part-way through a period. The divider, polarity and phase are taken in only while the clock is stopped.

Top module: `sclk_gen`

## Requirements
- R1: While reset is asserted and right after it, `sclk_o` is 0 and `launch_o` and `sample_o` are 0.
- R2: While stopped, `sclk_o` equals the captured polarity bit and neither strobe is asserted.
- R3: For a divider code `N` from 0 to 254, `sclk_o` toggles every `N+1` functional cycles, which gives a period of `2*(N+1)` cycles.
- R4: A stopped block starts at the clock edge where `run_i` is sampled high. The first `sclk_o` transition, away from the resting level, appears `N+1` cycles after that edge.
- R5: In divide mode each strobe is high for exactly the one cycle in which `sclk_o` first shows its new level, and the two strobes are never high together. With `cpha_i`=0, the leading edge (away from rest) gives `sample_o` and the trailing edge gives `launch_o`. With `cpha_i`=1 the roles are swapped.
- R6: In divide mode `run_i` is examined only at trailing edges. If it is low there, the clock stops at that edge with `sclk_o` at rest. Dropping `run_i` earlier does not shorten the period in progress.
- R7: The divider code, polarity and phase are captured only while stopped. Changes on those inputs while running have no effect until the next stop.
- R8: Code 0xFF selects pass-through. While running, `sclk_o` equals the functional clock (inverted when polarity is 1) and both strobes are high for each pass-through pulse. The first pulse is in the cycle after the start edge.
- R9: In pass-through mode, the number of pulses equals the number of clock edges at which `run_i` was sampled high. Each pulse falls in the cycle after its edge, and the pulse is always whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run request, high to run and low to stop |
| div_i | input | DIV_W | Divider code; all ones selects pass-through |
| cpol_i | input | 1 | Resting level of the serial clock |
| cpha_i | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| sclk_o | output | 1 | Serial clock pin level |
| launch_o | output | 1 | One-cycle strobe marking a data-launch edge |
| sample_o | output | 1 | One-cycle strobe marking a data-capture edge |

## Verification
The properties assume that the divider, polarity and phase inputs are only meaningful while stopped, and that `run_i` is a level that is synchronous to `clk`. The stimulus drives every input at the falling clock edge or shortly after a rising edge, never at a rising edge. It moves the configuration inputs while running only in the case that deliberately tests whether they are ignored. The pass-through pin is a gated copy of the clock, so the properties look at it only when divide mode is selected. The bench checks pass-through pulses by sampling both clock phases.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  typedef enum logic {
    ST_STOP = 1'b0,
    ST_RUN  = 1'b1
  } run_st_e;

  typedef struct packed {
    logic launch;
    logic sample;
  } strobe_t;
endpackage

// File: rtl/sclk_cfg.sv
module sclk_cfg #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             trail_tick,
  output logic             run_q,
  output logic [DIV_W-1:0] div_q,
  output logic             cpol_q,
  output logic             cpha_q,
  output logic             byp_q
);
  import sclk_pkg::*;
  localparam logic [DIV_W-1:0] BYP_CODE = {DIV_W{1'b1}};

  run_st_e st_q, st_d;
  logic    cfg_en;

  // configuration only accepted while stopped
  assign cfg_en = (st_q == ST_STOP);
  assign run_q  = (st_q == ST_RUN);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_STOP: if (run_i) st_d = ST_RUN;
      ST_RUN: begin
        if (byp_q) begin
          if (!run_i) st_d = ST_STOP;
        end else if (trail_tick && !run_i) begin
          st_d = ST_STOP;
        end
      end
      default: st_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_STOP;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      byp_q  <= 1'b0;
    end else if (cfg_en) begin
      div_q  <= div_i;
      cpol_q <= cpol_i;
      cpha_q <= cpha_i;
      byp_q  <= (div_i == BYP_CODE);
    end
  end
endmodule

// File: rtl/sclk_div.sv
module sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_q,
  input  logic             byp_q,
  input  logic [DIV_W-1:0] div_q,
  input  logic             cpha_q,
  output logic             lvl_q,
  output logic             trail_tick,
  output sclk_pkg::strobe_t stb_q
);
  import sclk_pkg::*;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             lvl_d, active, tick, lead;
  strobe_t          stb_d;

  assign active     = run_q && !byp_q;
  assign tick       = active && (cnt_q == div_q);
  assign lead       = !lvl_q;
  assign trail_tick = tick && lvl_q;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    stb_d = '0;
    if (!active) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (tick) begin
      cnt_d        = '0;
      lvl_d        = !lvl_q;
      stb_d.sample = lead ^ cpha_q;
      stb_d.launch = !(lead ^ cpha_q);
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
      stb_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
      stb_q <= stb_d;
    end
  end
endmodule

// File: rtl/sclk_byp.sv
module sclk_byp (
  input  logic clk,
  input  logic rst_n,
  input  logic run_q,
  input  logic byp_q,
  output logic gated,
  output logic stb_q
);
  logic pass, en_lo_q;

  assign pass = run_q && byp_q;

  // enable captured while clk is low so the gated pulse is never cut
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_lo_q <= 1'b0;
    else        en_lo_q <= pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= pass;
  end

  assign gated = clk && en_lo_q;
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  output logic             sclk_o,
  output logic             launch_o,
  output logic             sample_o
);
  import sclk_pkg::*;

  logic             run_q, cpol_q, cpha_q, byp_q;
  logic [DIV_W-1:0] div_q;
  logic             lvl_q, trail_tick, gated, byp_stb;
  strobe_t          stb_q;

  sclk_cfg #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .div_i(div_i),
    .cpol_i(cpol_i), .cpha_i(cpha_i), .trail_tick(trail_tick),
    .run_q(run_q), .div_q(div_q), .cpol_q(cpol_q), .cpha_q(cpha_q),
    .byp_q(byp_q)
  );

  sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .byp_q(byp_q),
    .div_q(div_q), .cpha_q(cpha_q), .lvl_q(lvl_q),
    .trail_tick(trail_tick), .stb_q(stb_q)
  );

  sclk_byp u_byp (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .byp_q(byp_q),
    .gated(gated), .stb_q(byp_stb)
  );

  assign sclk_o   = cpol_q ^ (byp_q ? gated : lvl_q);
  assign launch_o = byp_q ? byp_stb : stb_q.launch;
  assign sample_o = byp_q ? byp_stb : stb_q.sample;
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             byp_q,
  input logic             cpol_q,
  input logic [DIV_W-1:0] div_q,
  input logic             sclk_o,
  input logic             launch_o,
  input logic             sample_o
);
  // R7
  div_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> ($stable(div_q) && $stable(cpol_q)));

  // R6
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run_q) && !byp_q) |-> (sclk_o == cpol_q));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byp_q |-> !(launch_o && sample_o));

  // R5
  edge_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sclk_o) && $past(run_q) && !byp_q) |-> (launch_o || sample_o));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !$past(run_q)) |-> (!launch_o && !sample_o));
endmodule

bind sclk_gen sclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .byp_q(byp_q),
  .cpol_q(cpol_q), .div_q(div_q), .sclk_o(sclk_o),
  .launch_o(launch_o), .sample_o(sample_o)
);

// File: tb/sclk_gen_tb.sv
module sclk_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n, run, cpol, cpha;
  logic [7:0] div;
  logic       sclk, launch, sample;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  sclk_gen #(.DIV_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run), .div_i(div),
    .cpol_i(cpol), .cpha_i(cpha), .sclk_o(sclk),
    .launch_o(launch), .sample_o(sample)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int obs();
    return {29'd0, sclk, launch, sample};
  endfunction

  task automatic div_case(input int n, input bit pol, input bit pha,
                          input int hold, input bit chg, input string tag);
    int hp, tstop, h, lv, ev, lead, el, es, ipol, expv;
    @(negedge clk); div = n[7:0]; cpol = pol; cpha = pha; run = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(obs() == {29'd0, pol, 2'b00}, "R2 idle", obs(), {29'd0, pol, 2'b00});
    run = 1'b1;
    hp    = n + 1;
    tstop = ((hold + 1 + 2*hp - 1) / (2*hp)) * 2 * hp;
    ipol  = chg ? !pol : pol;
    for (int t = 0; t <= tstop + 3; t++) begin
      @(posedge clk); #1;
      if (t <= tstop) begin
        h    = t / hp;
        lv   = h % 2;
        ev   = (t > 0) && (t % hp == 0);
        lead = (h % 2 == 1);
        es   = ev && (lead ? !pha : pha);
        el   = ev && (lead ? pha : !pha);
        expv = {29'd0, pol ^ lv[0], el[0], es[0]};
      end else begin
        expv = {29'd0, ipol[0], 2'b00};
      end
      chk(obs() == expv, tag, obs(), expv);
      if (t == hold) run = 1'b0;
      if (chg && t == 1) begin div = n[7:0] + 8'd3; cpol = !pol; cpha = !pha; end
    end
  endtask

  task automatic byp_case(input bit pol, input int hold, input string tag);
    int act, expv;
    @(negedge clk); div = 8'hFF; cpol = pol; run = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(obs() == {29'd0, pol, 2'b00}, "R2 idle", obs(), {29'd0, pol, 2'b00});
    run = 1'b1;
    for (int t = 0; t <= hold + 4; t++) begin
      @(posedge clk); #1;
      act  = (t >= 1 && t <= hold + 1) ? 1 : 0;
      expv = {29'd0, pol ^ act[0], act[0], act[0]};
      chk(obs() == expv, tag, obs(), expv);
      #2;
      chk(sclk == pol, {tag, " low phase"}, sclk, pol);
      if (t == hold) run = 1'b0;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int nl[6] = '{0, 1, 2, 3, 5, 254};
    rst_n = 1'b0; run = 1'b0; div = 8'd0; cpol = 1'b0; cpha = 1'b0;
    repeat (3) @(negedge clk);
    chk(obs() == 0, "R1 in reset", obs(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(obs() == 0, "R1 after reset", obs(), 0);

    // R3 R4 R5: sweep divider codes and modes
    foreach (nl[i]) begin
      for (int m = 0; m < 4; m++) begin
        div_case(nl[i], m[1], m[0], (nl[i] == 254) ? 0 : 2*(nl[i]+1) + 1, 1'b0,
                 "R3 R4 R5 sweep");
      end
    end
    // R6: run dropped mid-period, stop waits for trailing edge
    div_case(2, 1'b0, 1'b1, 4, 1'b0, "R6 late stop");
    div_case(3, 1'b1, 1'b0, 0, 1'b0, "R6 early drop");
    // R7: config changes while running ignored
    div_case(2, 1'b0, 1'b0, 7, 1'b1, "R7 frozen cfg");
    div_case(1, 1'b1, 1'b1, 3, 1'b1, "R7 frozen cfg");
    // R8 R9: pass-through
    byp_case(1'b0, 5, "R8 pass-through");
    byp_case(1'b1, 5, "R8 pass-through");
    byp_case(1'b0, 0, "R9 single pulse");
    byp_case(1'b1, 2, "R9 pulse count");
    // back to divide after pass-through
    div_case(0, 1'b0, 1'b0, 1, 1'b0, "R3 after pass-through");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule